// File: doc/BRIEF.md
# Logical Shifted-Register Execute Unit

This unit takes one 32-bit instruction word per clock and, when the word belongs to the bitwise-logic-with-shifted-register group, carries out the whole operation in one pass. It reads two source registers through two external read ports. It shifts the second source by a 6-bit immediate and combines the two sources with one of eight bitwise operations. Writes to the destination register and, for the flag-setting forms, to the four condition flags come out one cycle later. An operand-size bit selects 64-bit or 32-bit operation. In 32-bit operation all work is done on the low half, and every written value is zero-extended.

The input is a plain valid strobe with no back-pressure. A word can be presented every cycle and is always accepted. Results appear on the following clock as single-cycle pulses. Words from other instruction groups are ignored so that a neighbouring decoder can claim them. A malformed 32-bit shift encoding produces a one-cycle undefined-instruction pulse and leaves all state alone.

Top module: `lsx_exec`

## Requirements
- R1: A word is claimed only when bits 28:24 equal 01010. Any other valid word gives no register write, no flag write and no undefined pulse on the next cycle.
- R2: The operation is chosen by {bit 21, bits 30:29}. 0 gives A&B, 1 gives A|B, 2 gives A^B, 3 gives A&B with flags, 4 gives A&~B, 5 gives A|~B, 6 gives ~(A^B), and 7 gives A&~B with flags. A is the first source (bits 9:5) and B is the shifted second source (bits 20:16).
- R3: The shift kind in bits 23:22 (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right) applies only to the second source. The amount comes from bits 15:10, and an amount of 0 leaves the source unchanged.
- R4: When bit 31 is 0 (32-bit operation), the unit works as follows. Arithmetic right shift copies bit 31 into the vacated positions. Rotate wraps within the low 32 bits. Bits 63:32 of the written data are zero.
- R5: When bit 31 is 0 and bit 15 is 1, the unit raises `undef` for exactly one cycle on the next clock. It performs no register write and no flag write, and `wr_idx`, `wr_data` and `nzcv` keep their values.
- R6: Only opcode 3 (bits 30:29) writes flags. The flags are `nzcv` = {N,Z,C,V}. N is the result sign (bit 63, or bit 31 in 32-bit operation), Z is set when the result is zero (only the low 32 bits count in 32-bit operation), and C and V are 0. `nzcv` holds its value in every other cycle.
- R7: The unit recognises a move form: opcode 1, shift kind 0, amount 0 and first source 31. For this form the destination receives the second source, or its complement when bit 21 is 1, zero-extended in 32-bit operation.
- R8: A source index of 31 reads as zero whatever the read port returns. A destination index of 31 suppresses `wr_en`, but the flags are still written.
- R9: Results are registered with one cycle of latency. `wr_en`, `flag_we` and `undef` are single-cycle pulses. `wr_idx` and `wr_data` change only for a claimed, allocated word and otherwise hold. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle (always accepted) |
| insn | input | 32 | Instruction word |
| rn_idx | output | 5 | First-source read index (bits 9:5) |
| rm_idx | output | 5 | Second-source read index (bits 20:16) |
| rn_data | input | 64 | First-source read data, same cycle |
| rm_data | input | 64 | Second-source read data, same cycle |
| wr_en | output | 1 | Destination write pulse |
| wr_idx | output | 5 | Destination index |
| wr_data | output | 64 | Destination write data |
| flag_we | output | 1 | Flag write pulse |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |
| undef | output | 1 | Unallocated-encoding pulse |

## Verification
Every stage from field extraction to the output registers sits in front of a single register rank. A wrong field slice, shift kind or operation select therefore shows up in `wr_data` or `nzcv` on the very next clock after the word is presented. A wrong enable or hold condition shows up as a stray or missing pulse, or as `nzcv`/`wr_data` drifting in a cycle where nothing was claimed. The bench compares all outputs with a behavioural model on every clock. A fault is therefore reported within one cycle of the instruction that exposes it.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef struct packed {
    logic       wide;
    logic [1:0] opc;
    shift_e     kind;
    logic       inv;
    logic [4:0] rm;
    logic [5:0] amt;
    logic [4:0] rn;
    logic [4:0] rd;
  } fields_t;

  localparam logic [4:0] GROUP_TAG  = 5'b01010;
  localparam logic [1:0] OPC_OR     = 2'd1;
  localparam logic [1:0] OPC_FLAGS  = 2'd3;
  localparam logic [4:0] ZERO_REG   = 5'd31;

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
(
  input  logic [31:0] insn,
  output fields_t     f,
  output logic        match,
  output logic        unalloc,
  output logic        mov_form
);
  always_comb begin
    f.wide = insn[31];
    f.opc  = insn[30:29];
    f.kind = shift_e'(insn[23:22]);
    f.inv  = insn[21];
    f.rm   = insn[20:16];
    f.amt  = insn[15:10];
    f.rn   = insn[9:5];
    f.rd   = insn[4:0];
  end

  assign match    = (insn[28:24] == GROUP_TAG);
  assign unalloc  = match && !f.wide && f.amt[5];
  assign mov_form = (f.opc == OPC_OR) && (f.amt == '0) &&
                    (f.kind == SH_LSL) && (f.rn == ZERO_REG);
endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter
  import lsx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                     wide,
  input  shift_e                   kind,
  input  logic [$clog2(XLEN)-1:0]  amt,
  input  logic [XLEN-1:0]          src,
  output logic [XLEN-1:0]          dst
);
  localparam int HALF = XLEN / 2;
  localparam int SW   = $clog2(XLEN);

  logic [HALF-1:0]   lo;
  logic [SW-2:0]     amt_lo;
  logic [XLEN-1:0]   full;
  logic [HALF-1:0]   half;
  logic [2*XLEN-1:0] dbl;
  logic [XLEN-1:0]   dbl_lo;

  assign lo     = src[HALF-1:0];
  assign amt_lo = amt[SW-2:0];

  always_comb begin
    dbl    = {src, src} >> amt;
    dbl_lo = {lo, lo} >> amt_lo;
    case (kind)
      SH_LSL: begin
        full = src << amt;
        half = lo << amt_lo;
      end
      SH_LSR: begin
        full = src >> amt;
        half = lo >> amt_lo;
      end
      SH_ASR: begin
        full = XLEN'($signed(src) >>> amt);
        half = HALF'($signed(lo) >>> amt_lo);
      end
      default: begin
        full = dbl[XLEN-1:0];
        half = dbl_lo[HALF-1:0];
      end
    endcase
    dst = wide ? full : {{HALF{1'b0}}, half};
  end
endmodule

// File: rtl/lsx_logic.sv
module lsx_logic #(
  parameter int XLEN = 64
) (
  input  logic            wide,
  input  logic [1:0]      opc,
  input  logic            inv,
  input  logic            mov_form,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            n_flag,
  output logic            z_flag
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] raw;

  always_comb begin
    if (mov_form) begin
      raw = inv ? ~b : b;
    end else begin
      case ({inv, opc})
        3'd0, 3'd3: raw = a & b;
        3'd1:       raw = a | b;
        3'd2:       raw = a ^ b;
        3'd4, 3'd7: raw = a & ~b;
        3'd5:       raw = a | ~b;
        default:    raw = ~(a ^ b);
      endcase
    end
    res    = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    n_flag = wide ? res[XLEN-1] : res[HALF-1];
    z_flag = (res == '0);
  end
endmodule

// File: rtl/lsx_exec.sv
module lsx_exec
  import lsx_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  output logic [4:0]        rn_idx,
  output logic [4:0]        rm_idx,
  input  logic [XLEN-1:0]   rn_data,
  input  logic [XLEN-1:0]   rm_data,
  output logic              wr_en,
  output logic [4:0]        wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              flag_we,
  output logic [3:0]        nzcv,
  output logic              undef
);
  localparam int          HALF = XLEN / 2;
  localparam int          SW   = $clog2(XLEN);
  localparam logic [4:0]  ZIDX = 5'(NREG - 1);

  fields_t         f;
  logic            match, unalloc, mov_form;
  logic [XLEN-1:0] op_a, op_b, op_b_sh, result;
  logic            n_flag, z_flag;
  logic            accept;

  lsx_decode u_dec (
    .insn     (insn),
    .f        (f),
    .match    (match),
    .unalloc  (unalloc),
    .mov_form (mov_form)
  );

  assign rn_idx = f.rn;
  assign rm_idx = f.rm;
  assign op_a   = (f.rn == ZIDX) ? '0 : rn_data;
  assign op_b   = (f.rm == ZIDX) ? '0 : rm_data;

  lsx_shifter #(.XLEN(XLEN)) u_shf (
    .wide (f.wide),
    .kind (f.kind),
    .amt  (f.amt[SW-1:0]),
    .src  (op_b),
    .dst  (op_b_sh)
  );

  lsx_logic #(.XLEN(XLEN)) u_log (
    .wide     (f.wide),
    .opc      (f.opc),
    .inv      (f.inv),
    .mov_form (mov_form),
    .a        (op_a),
    .b        (op_b_sh),
    .res      (result),
    .n_flag   (n_flag),
    .z_flag   (z_flag)
  );

  assign accept = in_valid && match && !unalloc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      flag_we <= 1'b0;
      nzcv    <= '0;
      undef   <= 1'b0;
    end else begin
      wr_en   <= accept && (f.rd != ZIDX);
      flag_we <= accept && (f.opc == OPC_FLAGS);
      undef   <= in_valid && unalloc;
      if (accept) begin
        wr_idx  <= f.rd;
        wr_data <= result;
        if (f.opc == OPC_FLAGS) nzcv <= {n_flag, z_flag, 2'b00};
      end
    end
  end

  // R1: foreign words leave no trace
  a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[28:24] != GROUP_TAG) |=> (!wr_en && !flag_we && !undef));

  // R4: 32-bit operation zero-extends
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && match && !insn[31] && !insn[15]) |=> (wr_data[XLEN-1:HALF] == '0));

  // R5: undefined pulse excludes writes
  a_r5_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!wr_en && !flag_we && $stable(nzcv) && $stable(wr_data)));

  // R6: flag contents agree with written data
  a_r6_flag_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (nzcv[1:0] == 2'b00 && nzcv[2] == (wr_data == '0)));

  // R6: flags hold without a flag write
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> $stable(nzcv));

  // R8: zero register never written
  a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != ZIDX));

  // R9: pulses only follow a valid word
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !flag_we && !undef));
endmodule

// File: tb/sim_lsx_exec.sv
`timescale 1ns/1ps
module sim_lsx_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [4:0]  rn_idx, rm_idx, wr_idx;
  logic [63:0] rn_data, rm_data, wr_data;
  logic        wr_en, flag_we, undef;
  logic [3:0]  nzcv;

  logic [63:0] regs [32];

  int tests = 0;
  int fails = 0;

  logic        e_wr_en = 0, e_flag_we = 0, e_undef = 0;
  logic [4:0]  e_wr_idx = 0;
  logic [63:0] e_wr_data = 0;
  logic [3:0]  e_nzcv = 0;
  string       e_req = "R9";

  always #2.5 clk = ~clk;

  assign rn_data = regs[rn_idx];
  assign rm_data = regs[rm_idx];

  lsx_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rn_idx(rn_idx), .rm_idx(rm_idx), .rn_data(rn_data), .rm_data(rm_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_we(flag_we), .nzcv(nzcv), .undef(undef)
  );

  function automatic logic [31:0] mk(input bit sf, input int opc, input int sh,
                                     input bit n, input int rm, input int imm,
                                     input int rn, input int rd);
    return {sf, 2'(opc), 5'b01010, 2'(sh), n, 5'(rm), 6'(imm), 5'(rn), 5'(rd)};
  endfunction

  function automatic logic [63:0] rdreg(input int i);
    return (i == 31) ? 64'd0 : regs[i];
  endfunction

  // behavioural reference: updates expected outputs for a word presented now
  function automatic void model(input bit v, input logic [31:0] w);
    bit sf = w[31];
    int opc = int'(w[30:29]);
    int sh = int'(w[23:22]);
    bit n = w[21];
    int amt = int'(w[15:10]);
    int rn = int'(w[9:5]);
    int rm = int'(w[20:16]);
    int rd = int'(w[4:0]);
    logic [63:0] a, b, r;
    logic [31:0] b32;
    e_wr_en = 0; e_flag_we = 0; e_undef = 0;
    if (!v || w[28:24] != 5'b01010) return;
    if (!sf && amt >= 32) begin e_undef = 1; return; end
    a = rdreg(rn);
    b = rdreg(rm);
    if (sf) begin
      case (sh)
        0: b = b << amt;
        1: b = b >> amt;
        2: b = 64'($signed(b) >>> amt);
        default: b = (b >> amt) | (b << (64 - amt));
      endcase
    end else begin
      b32 = b[31:0];
      case (sh)
        0: b32 = b32 << amt;
        1: b32 = b32 >> amt;
        2: b32 = 32'($signed(b32) >>> amt);
        default: b32 = (b32 >> amt) | (b32 << (32 - amt));
      endcase
      b = {32'd0, b32};
    end
    case ({n, 2'(opc)})
      3'd0, 3'd3: r = a & b;
      3'd1: r = a | b;
      3'd2: r = a ^ b;
      3'd4, 3'd7: r = a & ~b;
      3'd5: r = a | ~b;
      default: r = ~(a ^ b);
    endcase
    if (!sf) r[63:32] = 0;
    e_wr_en = (rd != 31);
    e_wr_idx = 5'(rd);
    e_wr_data = r;
    if (opc == 3) begin
      e_flag_we = 1;
      e_nzcv = {sf ? r[63] : r[31], r == 0, 2'b00};
    end
  endfunction

  task automatic check_now();
    tests++;
    if (wr_en !== e_wr_en || wr_idx !== e_wr_idx || wr_data !== e_wr_data ||
        flag_we !== e_flag_we || nzcv !== e_nzcv || undef !== e_undef) begin
      fails++;
      $display("FAIL %s actual we=%0b idx=%0d data=%h fwe=%0b nzcv=%b ud=%0b expected we=%0b idx=%0d data=%h fwe=%0b nzcv=%b ud=%0b",
               e_req, wr_en, wr_idx, wr_data, flag_we, nzcv, undef,
               e_wr_en, e_wr_idx, e_wr_data, e_flag_we, e_nzcv, e_undef);
    end
  endtask

  // one clock: check the previous word's result, then present the next word
  task automatic step(input bit v, input logic [31:0] w, input string req);
    @(negedge clk);
    check_now();
    in_valid = v;
    insn = w;
    model(v, w);
    e_req = req;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++)
      regs[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    regs[3]  = 64'hFFFF_FFFF_8000_0001;
    regs[4]  = 64'h8000_0000_0000_00F0;
    regs[5]  = 64'h0;
    regs[6]  = 64'hFFFF_FFFF_FFFF_FFFF;
    regs[7]  = 64'h1234_5678_0000_0000;
    regs[31] = 64'hDEAD_BEEF_CAFE_F00D;

    repeat (3) @(negedge clk);
    check_now();                     // R9 reset state
    rst_n = 1'b1;

    step(0, mk(1,0,0,0,4,0,3,1), "R9");              // valid low: ignored
    for (int op = 0; op < 8; op++)                   // R2 all eight operations
      step(1, mk(1, op & 3, 0, op >> 2, 4, 4, 3, 10 + op), "R2");
    for (int k = 0; k < 4; k++) begin                // R3 every shift kind, 64-bit
      step(1, mk(1,2,k,0,4,0,5,2), "R3");
      step(1, mk(1,2,k,0,4,1,5,2), "R3");
      step(1, mk(1,2,k,0,3,17,5,2), "R3");
      step(1, mk(1,2,k,0,4,63,5,2), "R3");
    end
    for (int k = 0; k < 4; k++) begin                // R4 32-bit shifts
      step(1, mk(0,1,k,0,3,0,5,2), "R4");
      step(1, mk(0,1,k,0,3,5,5,2), "R4");
      step(1, mk(0,1,k,0,6,31,5,2), "R4");
      step(1, mk(0,2,k,1,3,12,4,2), "R4");
    end
    step(1, mk(1,3,0,0,4,0,6,9), "R6");              // ANDS negative
    step(1, mk(1,3,0,0,4,0,5,9), "R6");              // ANDS zero
    step(1, mk(0,3,0,0,7,0,6,9), "R6");              // 32-bit: low half zero
    step(1, mk(0,3,0,1,5,0,3,9), "R6");              // BICS 32-bit negative
    step(1, mk(1,0,0,0,5,0,6,9), "R6");              // AND: flags hold
    step(1, mk(0,3,1,0,4,33,6,8), "R5");             // unallocated
    step(1, mk(0,0,2,1,4,63,6,8), "R5");             // unallocated, back to back
    step(1, mk(1,1,0,0,4,0,31,12), "R7");            // MOV 64
    step(1, mk(1,1,0,1,4,0,31,12), "R7");            // MVN 64
    step(1, mk(0,1,0,0,3,0,31,12), "R7");            // MOV 32
    step(1, mk(0,1,0,1,4,0,31,12), "R7");            // MVN 32
    step(1, mk(1,2,0,0,31,0,3,13), "R8");            // Rm = 31 reads zero
    step(1, mk(1,1,1,0,3,2,31,13), "R8");            // Rn = 31 with shift
    step(1, mk(1,3,0,0,4,0,6,31), "R8");             // Rd = 31: flags only
    step(1, {mk(1,0,0,0,4,0,3,1)} ^ 32'h0100_0000, "R1");
    step(1, {mk(1,3,0,0,4,0,5,1)} ^ 32'h1000_0000, "R1");
    step(0, 32'h0, "R1");
    step(0, 32'h0, "R9");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule